// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block keeps the pending state of sixteen software-raised interrupts for every CPU of a small cluster. For each pair of interrupt number and receiving CPU it holds a bitmap with one bit per requesting CPU, plus a pending flag. A CPU raises a software interrupt by writing a request word. The word names the interrupt number and a routing filter, and the requester's bit is then set in the bitmap of every CPU the filter selects.

A receiving CPU acknowledges an interrupt number. The block answers one cycle later with a word that carries the interrupt number and the lowest-numbered requesting CPU. It removes only that one requester, so two CPUs that raise the same interrupt at one target produce two separate acknowledges. Direct set and clear writes edit a bitmap with a byte mask. Choosing which interrupt to acknowledge, priorities and access filtering belong to the surrounding controller.

Top module: `sgi_pend_tracker`

## Requirements
- R1: After a synchronous active-low reset every bitmap and every pending flag is zero and no acknowledge result is presented.
- R2: A request word with filter field [25:24] = 0 targets exactly the CPUs whose bits are set in the list field [23:16]; the interrupt number is field [3:0].
- R3: Filter value 1 targets every CPU except the requester.
- R4: Filter value 2 targets the requester alone.
- R5: Filter value 3 is reserved and targets every CPU.
- R6: A request sets the requester's bit in the bitmap of each targeted CPU for that interrupt and sets those pending flags. All other bitmaps and flags are left unchanged.
- R7: An acknowledge of a pending interrupt yields, on the following cycle with ack_rvalid high, a word holding the interrupt number in bits [3:0] and the lowest set requester number in bits [12:10], with bits [9:4] zero.
- R8: An acknowledge clears only the reported requester bit. The pending flag stays set while bits remain and clears when the bitmap becomes empty.
- R9: An acknowledge of an interrupt that is not pending yields 1023 and changes no state.
- R10: A clear write removes the written byte's bits from the bitmap, and it clears the pending flag if the bitmap is then empty.
- R11: A set write ORs the written byte into the bitmap and sets the pending flag even when the byte is zero. Acknowledging such an entry with an empty bitmap reports requester 0 and clears the flag.
- R12: Within one cycle, clears from an acknowledge or clear write are applied before sets from a request or set write. The acknowledge reports the bitmap held before that cycle.
- R13: The read port shows, combinationally, the bitmap selected by rd_cpu and rd_id. Pending flag of CPU t and interrupt i is bit t*16+i of pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_valid | input | 1 | Request word strobe |
| gen_cpu | input | CPU_W | Requesting CPU |
| gen_word | input | 32 | Request word: number [3:0], list [23:16], filter [25:24] |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Acknowledging CPU |
| ack_id | input | 4 | Interrupt number being acknowledged |
| ack_rvalid | output | 1 | Acknowledge result valid |
| ack_word | output | 13 | Acknowledge result |
| spnd_valid | input | 1 | Direct bitmap write strobe |
| spnd_clear | input | 1 | 1 clears bits, 0 sets bits |
| spnd_cpu | input | CPU_W | CPU whose bitmap is written |
| spnd_id | input | 4 | Interrupt number written |
| spnd_bits | input | NUM_CPU | Requester bit mask |
| pending | output | NUM_CPU*16 | Pending flags, bit t*16+i |
| rd_cpu | input | CPU_W | Read port CPU select |
| rd_id | input | 4 | Read port interrupt select |
| rd_bitmap | output | NUM_CPU | Selected requester bitmap |

## Verification
Bitmap and pending changes made by a request, acknowledge or direct write show up one clock edge after the strobe. The acknowledge word is due on that same edge, since it is registered from the bitmap held before the edge. The read port follows state with no added latency. Inputs are driven on the falling edge, and every result is sampled on the next falling edge, after exactly one rising edge. The bench then sweeps the read port across all entries within that low phase.

// File: rtl/sgi_trk_pkg.sv
// Shared constants and types for the software interrupt source tracker.
package sgi_trk_pkg;
    localparam int SGI_COUNT = 16;
    localparam int ID_W      = 4;
    localparam int WORD_W    = 13;
    localparam int SRC_LSB   = 10;
    localparam logic [WORD_W-1:0] SPURIOUS = 13'd1023;

    // Routing filter carried in the request word.
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } tgt_filter_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Resolves the routing filter of a request word into a CPU target mask.
// Assumes req_cpu < NUM_CPU. The reserved encoding selects every CPU.
module sgi_target_decode
    import sgi_trk_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int CPU_W   = 3
) (
    input  logic [1:0]         filter,
    input  logic [NUM_CPU-1:0] list,
    input  logic [CPU_W-1:0]   req_cpu,
    output logic [NUM_CPU-1:0] mask
);
    logic [NUM_CPU-1:0] self_1h;

    // One-hot of the requester.
    always_comb begin
        self_1h = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (CPU_W'(c) == req_cpu) self_1h[c] = 1'b1;
        end
    end

    // Filter selection.
    always_comb begin
        case (tgt_filter_e'(filter))
            FLT_LIST:   mask = list;
            FLT_OTHERS: mask = ~self_1h;
            FLT_SELF:   mask = self_1h;
            default:    mask = '1;
        endcase
    end
endmodule

// File: rtl/sgi_src_cell.sv
// One (interrupt, target CPU) entry: requester bitmap plus pending flag.
// Assumes set_pend is high whenever set_bits is non-zero. Clears are applied
// before sets; the flag drops only on a clear event that empties the bitmap.
module sgi_src_cell #(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] set_bits,
    input  logic [NUM_CPU-1:0] clr_bits,
    input  logic               set_pend,
    input  logic               clr_evt,
    output logic [NUM_CPU-1:0] bitmap,
    output logic               pend
);
    logic [NUM_CPU-1:0] bm_n;
    logic               pend_n;

    // Next-state merge: clear first, then set.
    always_comb begin
        bm_n   = (bitmap & ~clr_bits) | set_bits;
        pend_n = set_pend | (pend & !(clr_evt && (bm_n == '0)));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitmap <= '0;
            pend   <= 1'b0;
        end else begin
            bitmap <= bm_n;
            pend   <= pend_n;
        end
    end
endmodule

// File: rtl/sgi_ack_unit.sv
// Picks the lowest requester of the acknowledged entry and registers the
// result word. Assumes NUM_CPU <= 8 so the requester fits three bits.
module sgi_ack_unit
    import sgi_trk_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_valid,
    input  logic [ID_W-1:0]    ack_id,
    input  logic [NUM_CPU-1:0] sel_bitmap,
    input  logic               sel_pend,
    output logic [NUM_CPU-1:0] low_1h,
    output logic               ack_rvalid,
    output logic [WORD_W-1:0]  ack_word
);
    logic [2:0] low_idx;

    // Lowest set bit, as index and one-hot; index 0 when empty.
    always_comb begin
        low_idx = '0;
        low_1h  = '0;
        for (int c = NUM_CPU - 1; c >= 0; c--) begin
            if (sel_bitmap[c]) begin
                low_idx = 3'(c);
                low_1h  = '0;
                low_1h[c] = 1'b1;
            end
        end
    end

    // Registered acknowledge result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_rvalid <= 1'b0;
            ack_word   <= '0;
        end else begin
            ack_rvalid <= ack_valid;
            if (ack_valid) begin
                ack_word <= sel_pend ? {low_idx, 6'b0, ack_id} : SPURIOUS;
            end
        end
    end
endmodule

// File: rtl/sgi_pend_tracker.sv
// Top of the software interrupt source tracker. Holds a requester bitmap and
// pending flag per (interrupt, CPU) and applies request, acknowledge and
// direct-write events. Assumes NUM_CPU between 2 and 8 and CPU inputs < NUM_CPU.
module sgi_pend_tracker
    import sgi_trk_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int CPU_W   = $clog2(NUM_CPU)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         gen_valid,
    input  logic [CPU_W-1:0]             gen_cpu,
    input  logic [31:0]                  gen_word,
    input  logic                         ack_valid,
    input  logic [CPU_W-1:0]             ack_cpu,
    input  logic [3:0]                   ack_id,
    output logic                         ack_rvalid,
    output logic [12:0]                  ack_word,
    input  logic                         spnd_valid,
    input  logic                         spnd_clear,
    input  logic [CPU_W-1:0]             spnd_cpu,
    input  logic [3:0]                   spnd_id,
    input  logic [NUM_CPU-1:0]           spnd_bits,
    output logic [NUM_CPU*SGI_COUNT-1:0] pending,
    input  logic [CPU_W-1:0]             rd_cpu,
    input  logic [3:0]                   rd_id,
    output logic [NUM_CPU-1:0]           rd_bitmap
);
    logic [NUM_CPU-1:0] bm_q   [SGI_COUNT][NUM_CPU];
    logic               pend_q [SGI_COUNT][NUM_CPU];
    logic [NUM_CPU-1:0] tgt_mask;
    logic [NUM_CPU-1:0] gen_1h;
    logic [NUM_CPU-1:0] low_1h;
    logic [ID_W-1:0]    gen_id;
    logic               unused_word_bits;

    assign gen_id           = gen_word[3:0];
    assign unused_word_bits = ^{gen_word[31:26], gen_word[15:4]};

    sgi_target_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_decode (
        .filter  (gen_word[25:24]),
        .list    (gen_word[16 +: NUM_CPU]),
        .req_cpu (gen_cpu),
        .mask    (tgt_mask)
    );

    // Requester one-hot for bitmap setting.
    always_comb begin
        gen_1h = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (CPU_W'(c) == gen_cpu) gen_1h[c] = 1'b1;
        end
    end

    sgi_ack_unit #(.NUM_CPU(NUM_CPU)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_valid  (ack_valid),
        .ack_id     (ack_id),
        .sel_bitmap (bm_q[ack_id][ack_cpu]),
        .sel_pend   (pend_q[ack_id][ack_cpu]),
        .low_1h     (low_1h),
        .ack_rvalid (ack_rvalid),
        .ack_word   (ack_word)
    );

    assign rd_bitmap = bm_q[rd_id][rd_cpu];

    for (genvar gi = 0; gi < SGI_COUNT; gi++) begin : g_id
        for (genvar gt = 0; gt < NUM_CPU; gt++) begin : g_cpu
            logic               gen_hit, ack_hit, wr_hit;
            logic [NUM_CPU-1:0] set_bits, clr_bits;
            logic               set_pend, clr_evt;

            // Per-entry event decode.
            always_comb begin
                gen_hit  = gen_valid && (gen_id == ID_W'(gi)) && tgt_mask[gt];
                ack_hit  = ack_valid && (ack_id == ID_W'(gi)) &&
                           (ack_cpu == CPU_W'(gt)) && pend_q[gi][gt];
                wr_hit   = spnd_valid && (spnd_id == ID_W'(gi)) &&
                           (spnd_cpu == CPU_W'(gt));
                set_bits = (gen_hit ? gen_1h : '0) |
                           ((wr_hit && !spnd_clear) ? spnd_bits : '0);
                clr_bits = (ack_hit ? low_1h : '0) |
                           ((wr_hit && spnd_clear) ? spnd_bits : '0);
                set_pend = gen_hit || (wr_hit && !spnd_clear);
                clr_evt  = ack_hit || (wr_hit && spnd_clear);
            end

            sgi_src_cell #(.NUM_CPU(NUM_CPU)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_bits (set_bits),
                .clr_bits (clr_bits),
                .set_pend (set_pend),
                .clr_evt  (clr_evt),
                .bitmap   (bm_q[gi][gt]),
                .pend     (pend_q[gi][gt])
            );

            assign pending[gt*SGI_COUNT + gi] = pend_q[gi][gt];
        end
    end
endmodule

// File: rtl/sgi_pend_tracker_chk.sv
// Port-level temporal checks for the tracker, attached by bind.
module sgi_pend_tracker_chk #(
    parameter int NUM_CPU = 8,
    parameter int CPU_W   = $clog2(NUM_CPU)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    gen_valid,
    input logic [CPU_W-1:0]        gen_cpu,
    input logic [31:0]             gen_word,
    input logic                    ack_valid,
    input logic [3:0]              ack_id,
    input logic                    ack_rvalid,
    input logic [12:0]             ack_word,
    input logic                    spnd_valid,
    input logic                    spnd_clear,
    input logic [CPU_W-1:0]        spnd_cpu,
    input logic [3:0]              spnd_id,
    input logic [NUM_CPU*16-1:0]   pending
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && !ack_rvalid)); // R1

    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> ack_rvalid); // R7

    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> !ack_rvalid); // R7

    AST_ACK_ID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (ack_word == 13'd1023 ||
                       (ack_word[3:0] == $past(ack_id) && ack_word[9:4] == 6'd0))); // R7

    AST_ACK_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rvalid && ack_word != 13'd1023) |-> (int'(ack_word[12:10]) < NUM_CPU)); // R7

    AST_SELF_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && gen_word[25:24] == 2'd2) |=>
            pending[int'($past(gen_cpu))*16 + int'($past(gen_word[3:0]))]); // R4

    AST_SET_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (spnd_valid && !spnd_clear) |=>
            pending[int'($past(spnd_cpu))*16 + int'($past(spnd_id))]); // R11
endmodule

bind sgi_pend_tracker sgi_pend_tracker_chk #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_valid  (gen_valid),
    .gen_cpu    (gen_cpu),
    .gen_word   (gen_word),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .ack_rvalid (ack_rvalid),
    .ack_word   (ack_word),
    .spnd_valid (spnd_valid),
    .spnd_clear (spnd_clear),
    .spnd_cpu   (spnd_cpu),
    .spnd_id    (spnd_id),
    .pending    (pending)
);

// File: tb/sgi_pend_tracker_test.sv
`timescale 1ns/1ps
module sgi_pend_tracker_test;
    localparam int NC = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gen_valid;
    logic [2:0]  gen_cpu;
    logic [31:0] gen_word;
    logic        ack_valid;
    logic [2:0]  ack_cpu;
    logic [3:0]  ack_id;
    logic        ack_rvalid;
    logic [12:0] ack_word;
    logic        spnd_valid, spnd_clear;
    logic [2:0]  spnd_cpu;
    logic [3:0]  spnd_id;
    logic [7:0]  spnd_bits;
    logic [127:0] pending;
    logic [2:0]  rd_cpu;
    logic [3:0]  rd_id;
    logic [7:0]  rd_bitmap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_bm [16][8];
    bit         m_pd [16][8];

    sgi_pend_tracker #(.NUM_CPU(NC)) uut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [7:0] tgt_mask(logic [1:0] f, logic [7:0] l, logic [2:0] r);
        case (f)
            2'd0: return l;
            2'd1: return ~(8'd1 << r);
            2'd2: return 8'd1 << r;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int lowest(logic [7:0] b);
        for (int c = 0; c < 8; c++) if (b[c]) return c;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every entry through the read port plus the pending vector.
    task automatic check_state(string req);
        logic [127:0] exp_p = '0;
        int bad_i = -1, bad_t = -1;
        logic [7:0] bad_a = 0;
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 16; i++) begin
                exp_p[t*16+i] = m_pd[i][t];
                rd_cpu = 3'(t); rd_id = 4'(i);
                #0.01;
                if (rd_bitmap !== m_bm[i][t] && bad_i < 0) begin
                    bad_i = i; bad_t = t; bad_a = rd_bitmap;
                end
            end
        check(pending === exp_p, req, "pending", pending, exp_p);
        check(bad_i < 0, req, "bitmap", 128'(bad_a),
              bad_i < 0 ? 128'd0 : 128'(m_bm[bad_i][bad_t]));
    endtask

    // Drive one cycle of events on the falling edge, check on the next one.
    task automatic step(bit gv, logic [2:0] gc, logic [31:0] gw,
                        bit av, logic [2:0] ac, logic [3:0] aid,
                        bit sv, bit sc, logic [2:0] scpu, logic [3:0] sid, logic [7:0] sb,
                        string req);
        logic [12:0] exp_w;
        logic [7:0]  clr [16][8];
        logic [7:0]  set [16][8];
        bit          sp  [16][8];
        bit          ce  [16][8];
        logic [7:0]  m;
        for (int i = 0; i < 16; i++)
            for (int t = 0; t < 8; t++) begin
                clr[i][t] = 0; set[i][t] = 0; sp[i][t] = 0; ce[i][t] = 0;
            end
        gen_valid = gv; gen_cpu = gc; gen_word = gw;
        ack_valid = av; ack_cpu = ac; ack_id = aid;
        spnd_valid = sv; spnd_clear = sc; spnd_cpu = scpu; spnd_id = sid; spnd_bits = sb;
        exp_w = 13'd1023;
        if (av && m_pd[aid][ac]) begin
            exp_w = {3'(lowest(m_bm[aid][ac])), 6'd0, aid};
            if (m_bm[aid][ac] != 0) clr[aid][ac] |= 8'd1 << lowest(m_bm[aid][ac]);
            ce[aid][ac] = 1;
        end
        if (gv) begin
            m = tgt_mask(gw[25:24], gw[23:16], gc);
            for (int t = 0; t < 8; t++)
                if (m[t]) begin set[gw[3:0]][t] |= 8'd1 << gc; sp[gw[3:0]][t] = 1; end
        end
        if (sv) begin
            if (sc) begin clr[sid][scpu] |= sb; ce[sid][scpu] = 1; end
            else begin set[sid][scpu] |= sb; sp[sid][scpu] = 1; end
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 16; i++)
            for (int t = 0; t < 8; t++) begin
                m_bm[i][t] = (m_bm[i][t] & ~clr[i][t]) | set[i][t];
                m_pd[i][t] = sp[i][t] | (m_pd[i][t] & !(ce[i][t] && m_bm[i][t] == 0));
            end
        check(ack_rvalid === av, req, "ack_rvalid", 128'(ack_rvalid), 128'(av));
        if (av) check(ack_word === exp_w, req, "ack_word", 128'(ack_word), 128'(exp_w));
        gen_valid = 0; ack_valid = 0; spnd_valid = 0;
        check_state(req);
    endtask

    function automatic logic [31:0] word(logic [1:0] f, logic [7:0] l, logic [3:0] id);
        return {6'd0, f, l, 12'd0, id};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 16; i++)
            for (int t = 0; t < 8; t++) begin m_bm[i][t] = 0; m_pd[i][t] = 0; end
        rst_n = 0;
        gen_valid = 0; gen_cpu = 0; gen_word = 0;
        ack_valid = 0; ack_cpu = 0; ack_id = 0;
        spnd_valid = 0; spnd_clear = 0; spnd_cpu = 0; spnd_id = 0; spnd_bits = 0;
        rd_cpu = 0; rd_id = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(ack_rvalid === 1'b0, "R1", "ack_rvalid", 128'(ack_rvalid), 0);
        check_state("R1");
        // R4 requester only, R6 only that entry
        step(1, 3'd3, word(2'd2, 8'h00, 4'd5), 0,0,0, 0,0,0,0,0, "R4");
        // R2 explicit list
        step(1, 3'd1, word(2'd0, 8'h96, 4'd2), 0,0,0, 0,0,0,0,0, "R2");
        // R3 all but requester
        step(1, 3'd0, word(2'd1, 8'h00, 4'd7), 0,0,0, 0,0,0,0,0, "R3");
        // R5 reserved filter means all
        step(1, 3'd6, word(2'd3, 8'h00, 4'd15), 0,0,0, 0,0,0,0,0, "R5");
        // R6 second requester into cpu4 id2
        step(1, 3'd5, word(2'd0, 8'h10, 4'd2), 0,0,0, 0,0,0,0,0, "R6");
        // R7 R8 acks consume lowest source first
        step(0,0,0, 1, 3'd4, 4'd2, 0,0,0,0,0, "R7");
        step(0,0,0, 1, 3'd4, 4'd2, 0,0,0,0,0, "R8");
        // R9 not pending gives 1023
        step(0,0,0, 1, 3'd4, 4'd2, 0,0,0,0,0, "R9");
        // R11 set write with zero byte, then ack reports source 0
        step(0,0,0, 0,0,0, 1, 0, 3'd0, 4'd9, 8'h00, "R11");
        step(0,0,0, 1, 3'd0, 4'd9, 0,0,0,0,0, "R11");
        // R10 partial then full clear
        step(0,0,0, 0,0,0, 1, 0, 3'd2, 4'd4, 8'hA0, "R10");
        step(0,0,0, 0,0,0, 1, 1, 3'd2, 4'd4, 8'h20, "R10");
        step(0,0,0, 0,0,0, 1, 1, 3'd2, 4'd4, 8'h80, "R10");
        // R12 ack and request on the same entry in one cycle
        step(1, 3'd3, word(2'd2, 8'h00, 4'd5), 1, 3'd3, 4'd5, 0,0,0,0,0, "R12");
        // R13 R6 R8 random mix
        for (int n = 0; n < 800; n++) begin
            bit gv = ($urandom % 3) == 0;
            bit av = ($urandom % 2) == 0;
            bit sv = ($urandom % 4) == 0;
            logic [31:0] gw = word(2'($urandom), 8'($urandom), 4'($urandom % 4));
            step(gv, 3'($urandom), gw,
                 av, 3'($urandom), 4'($urandom % 4),
                 sv, 1'($urandom), 3'($urandom), 4'($urandom % 4), 8'($urandom),
                 "R13");
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule